// File: doc/BRIEF.md
# SPI Master Serial Clock Generator and Shifter

This block runs an 8-bit SPI master transfer from one system clock. A start strobe loads a parallel transmit word. The block then derives the serial clock by dividing the system clock by a programmable baud value, sends the word MSB first on MOSI, and collects the word arriving on MISO. Clock phase is fixed at zero. The polarity input sets the idle level of the serial clock, and therefore also sets which edge launches data and which edge samples it.

When the block starts a transfer, it captures the baud value and the polarity. Later changes on those inputs do not affect a transfer that is already running. When the last bit has been sampled, the block raises a one-cycle completion pulse, drops busy, and keeps the received word on its output until another transfer completes. Odd divide ratios produce an intentionally uneven serial clock: the level entered at the launch edge is one system clock shorter than the idle level. Baud values below 3 are clamped to a period of four system clocks.

Top module: `spi_master_core`

## Requirements
- R1: During and directly after reset, busy_o and done_o are 0, rx_data_o is 0, and sclk_o equals cpol_i.
- R2: While no transfer is running, sclk_o follows cpol_i.
- R3: For baud_i of 3 or more, the serial clock period is baud_i+1 system clocks.
- R4: baud_i values 0, 1 and 2 give a period of 4 system clocks, with 2 clocks at each level.
- R5: Let P be the period. The level entered at the launch edge lasts floor(P/2) clocks, and the idle level lasts P minus that. For odd P the launch-side level is therefore one clock shorter.
- R6: MOSI carries tx_data_i[7] from the cycle after start is accepted. Each transfer begins with one idle-level phase and then a launch edge. Each later bit, in order from bit 6 down to bit 0, appears on a launch edge. The launch edge is rising for polarity 0 and falling for polarity 1.
- R7: MISO is sampled on the edge that returns sclk_o to the idle level, MSB first. The eight samples form rx_data_o, with the first sample in bit 7.
- R8: In the cycle after the eighth sample edge, done_o is 1 for exactly one cycle, busy_o is 0, and sclk_o is at the idle level.
- R9: A start_i pulse while busy_o is 1 has no effect on the running transfer.
- R10: rx_data_o changes only in the cycle in which done_o is high.
- R11: baud_i and cpol_i are captured when a transfer starts. Changing them during the transfer does not change sclk_o timing or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transfer when idle |
| tx_data_i | input | 8 | Word to send |
| baud_i | input | 7 | Divide setting; period is max(4, baud_i+1) |
| cpol_i | input | 1 | Clock polarity and idle level |
| miso_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| rx_data_o | output | 8 | Last received word |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A corrupted half-period counter or phase flag shows up at the first edge that follows it: sclk_o flips one or more cycles away from the expected position. The per-cycle model catches this on that same cycle. A wrong bit index or shift-register value shows on mosi_o at the next launch edge. It also shows on rx_data_o as soon as done_o rises, and a miscounted bit index also moves done_o by a whole serial period. Captured settings that have gone stale or been overwritten show up as a changed sclk_o level or period in the first cycle after the disturbing input.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  // baud settings below this value are clamped to the minimum period
  localparam int unsigned CLAMP_BELOW = 3;
  localparam int unsigned MIN_PERIOD  = 4;

  typedef enum logic {
    PH_IDLE_LVL = 1'b0,
    PH_ACT_LVL  = 1'b1
  } sclk_phase_e;
endpackage

// File: rtl/spi_baud_calc.sv
module spi_baud_calc
  import spi_master_pkg::*;
#(
  parameter int BAUD_W = 7,
  localparam int PER_W = BAUD_W + 1
) (
  input  logic [BAUD_W-1:0] baud_i,
  output logic [PER_W-1:0]  short_o,
  output logic [PER_W-1:0]  long_o
);
  logic [PER_W-1:0] per;

  always_comb begin
    if (baud_i < BAUD_W'(CLAMP_BELOW)) per = PER_W'(MIN_PERIOD);
    else                               per = PER_W'(baud_i) + PER_W'(1);
    short_o = per >> 1;
    long_o  = per - short_o;
  end
endmodule

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer
  import spi_master_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic             pol_i,
  input  logic [PER_W-1:0] short_i,
  input  logic [PER_W-1:0] long_i,
  output logic             sclk_o,
  output logic             act_o,
  output logic             smp_o
);
  logic [PER_W-1:0] cnt_q, short_q, long_q;
  logic             pol_q, sclk_q;
  sclk_phase_e      phase_q;
  logic             expire;

  assign expire = run_i && (cnt_q == '0);
  assign act_o  = expire && (phase_q == PH_IDLE_LVL);
  assign smp_o  = expire && (phase_q == PH_ACT_LVL);
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      short_q <= '0;
      long_q  <= '0;
      pol_q   <= 1'b0;
      sclk_q  <= 1'b0;
      phase_q <= PH_IDLE_LVL;
    end else if (load_i) begin
      short_q <= short_i;
      long_q  <= long_i;
      pol_q   <= pol_i;
      sclk_q  <= pol_i;
      phase_q <= PH_IDLE_LVL;
      cnt_q   <= long_i - PER_W'(1);
    end else if (act_o) begin
      sclk_q  <= ~pol_q;
      phase_q <= PH_ACT_LVL;
      cnt_q   <= short_q - PER_W'(1);
    end else if (smp_o) begin
      sclk_q  <= pol_q;
      phase_q <= PH_IDLE_LVL;
      cnt_q   <= long_q - PER_W'(1);
    end else if (run_i) begin
      cnt_q   <= cnt_q - PER_W'(1);
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              act_i,
  input  logic              smp_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] shift_next_o
);
  logic [DATA_W-1:0] sh_q;
  logic              mosi_q;

  assign shift_next_o = {sh_q[DATA_W-2:0], miso_i};
  assign mosi_o       = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= tx_i;
      mosi_q <= tx_i[DATA_W-1];
    end else begin
      // launch edge puts the current MSB out; sample edge shifts MISO in
      if (act_i) mosi_q <= sh_q[DATA_W-1];
      if (smp_i) sh_q   <= shift_next_o;
    end
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BAUD_W = 7,
  localparam int PER_W = BAUD_W + 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              cpol_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, done_q, load;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] rx_q, shift_next;
  logic [PER_W-1:0]  short_len, long_len;
  logic              sclk_t, act, smp;

  assign load = start_i && !busy_q;

  spi_baud_calc #(.BAUD_W(BAUD_W)) i_baud (
    .baud_i (baud_i),
    .short_o(short_len),
    .long_o (long_len)
  );

  spi_sclk_timer #(.PER_W(PER_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .run_i  (busy_q),
    .pol_i  (cpol_i),
    .short_i(short_len),
    .long_i (long_len),
    .sclk_o (sclk_t),
    .act_o  (act),
    .smp_o  (smp)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .tx_i        (tx_data_i),
    .act_i       (act),
    .smp_i       (smp),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .shift_next_o(shift_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        bit_q  <= '0;
      end else if (smp) begin
        if (bit_q == BIT_W'(DATA_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          rx_q   <= shift_next;
        end else begin
          bit_q  <= bit_q + BIT_W'(1);
        end
      end
    end
  end

  assign sclk_o    = busy_q ? sclk_t : cpol_i;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
endmodule

// File: rtl/spi_master_checker.sv
module spi_master_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpol_i,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              busy_o,
  input logic              done_o
);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && !busy_o);

  assert_done_idle_lvl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sclk_o == cpol_i);

  assert_rx_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rx_data_o));

  assert_mosi_on_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$stable(mosi_o)) |-> !$stable(sclk_o));

  assert_idle_clk_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o == cpol_i);
endmodule

bind spi_master_core spi_master_checker #(.DATA_W(DATA_W)) i_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cpol_i   (cpol_i),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .rx_data_o(rx_data_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/test_spi_master_core.sv
`timescale 1ns/1ps
module test_spi_master_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic [6:0] baud_i = '0;
  logic       cpol_i = 1'b0;
  logic       miso_i = 1'b0;
  logic       sclk_o, mosi_o, busy_o, done_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] last_rx = '0;

  always #2.5 clk_i = ~clk_i;

  spi_master_core i_spi_master_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .tx_data_i(tx_data_i),
    .baud_i   (baud_i),
    .cpol_i   (cpol_i),
    .miso_i   (miso_i),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .rx_data_o(rx_data_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // one cycle of the reference model: compare every observable port
  task automatic cyc(logic sclk_e, logic mosi_e, logic busy_e, logic done_e, logic [7:0] rx_e);
    chk("R3/R4/R5/R11 sclk", 32'(sclk_o), 32'(sclk_e));
    chk("R6 mosi", 32'(mosi_o), 32'(mosi_e));
    chk("R8/R9 busy", 32'(busy_o), 32'(busy_e));
    chk("R8 done", 32'(done_o), 32'(done_e));
    chk("R7/R10 rx", 32'(rx_data_o), 32'(rx_e));
  endtask

  task automatic xfer(logic [7:0] tx, int baud, logic pol, logic [7:0] rxpat, bit disturb);
    int per, hi_len, lo_len;
    logic prev_mosi;
    per    = (baud < 3) ? 4 : baud + 1;   // R3, R4
    hi_len = per / 2;                      // R5 launch-side level
    lo_len = per - hi_len;                 // R5 idle level
    @(negedge clk_i);
    start_i = 1'b1; tx_data_i = tx; baud_i = 7'(baud); cpol_i = pol;
    @(negedge clk_i);
    start_i = 1'b0;
    prev_mosi = tx[7];
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < lo_len; i++) begin
        cyc(pol, prev_mosi, 1'b1, 1'b0, last_rx);
        if (disturb && b == 3 && i == 0) begin
          // R9, R11: start, new word, new baud and new polarity while busy
          start_i = 1'b1; tx_data_i = ~tx; baud_i = 7'd9; cpol_i = ~pol;
        end else if (disturb && b == 3 && i == 1) begin
          start_i = 1'b0; baud_i = 7'(baud); cpol_i = pol;
        end
        @(negedge clk_i);
      end
      miso_i = rxpat[7-b];
      prev_mosi = tx[7-b];
      for (int i = 0; i < hi_len; i++) begin
        cyc(~pol, tx[7-b], 1'b1, 1'b0, last_rx);
        @(negedge clk_i);
      end
    end
    last_rx = rxpat;
    cyc(pol, tx[0], 1'b0, 1'b1, rxpat);   // R8 done pulse, R7 word
    @(negedge clk_i);
    cyc(pol, tx[0], 1'b0, 1'b0, rxpat);   // R8 single cycle, R10 held
  endtask

  initial begin
    cpol_i = 1'b1;
    #12;
    // R1 reset state with polarity 1
    chk("R1 sclk", 32'(sclk_o), 32'd1);
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 rx", 32'(rx_data_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    // R2 idle level follows polarity
    cpol_i = 1'b0; #1;
    chk("R2 idle low", 32'(sclk_o), 32'd0);
    cpol_i = 1'b1; #1;
    chk("R2 idle high", 32'(sclk_o), 32'd1);

    xfer(8'hA5, 0, 1'b0, 8'h3C, 0);   // R4 clamp
    xfer(8'h5A, 1, 1'b1, 8'hC3, 0);   // R4 clamp
    xfer(8'h81, 2, 1'b0, 8'h7E, 0);   // R4 clamp
    xfer(8'hF0, 3, 1'b1, 8'h0F, 0);   // R3 period 4
    xfer(8'h96, 4, 1'b0, 8'h69, 0);   // R5 odd period 5
    xfer(8'h1E, 8, 1'b1, 8'hE1, 0);   // R5 odd period 9, polarity 1
    xfer(8'hC7, 5, 1'b0, 8'h55, 1);   // R9, R11 disturbance
    xfer(8'h3B, 6, 1'b1, 8'hAA, 1);   // R9, R11 polarity 1
    xfer(8'h00, 127, 1'b0, 8'hFF, 0); // R3 period 128
    xfer(8'hFF, 126, 1'b1, 8'h00, 0); // R5 odd period 127

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule